// File: doc/BRIEF.md
# Flash Command Decoder

This block is the command front end of a NOR-style flash device. On every clock edge where the bus chip enable and write enable are both high, it treats the low byte of the bus data word as a command code. It follows the two-step program sequence and the two-step block erase sequence, and it issues single-cycle requests to the internal operation sequencer: start program, start erase, lock, suspend and resume. It also picks which view a bus read returns: array, status, identification or query.

Which codes are legal depends on two status inputs from the sequencer, busy and suspended. The block also remembers whether the operation that was last started fresh was a program or an erase. While an operation runs, only suspend is accepted. While an operation is held, a restricted set is accepted, and that set depends on the kind of operation held. A program may run inside an erase suspend, and the erase can be resumed once that program has finished. Any code that is not legal in the current state is dropped and leaves the block as it was.

Top module: `flash_cmd_ui`

## Requirements
- R1: While rst_n is low, and after it rises, read_mode is 0 (array) and all request pulses are low.
- R2: With no operation busy or held, codes FFh, 70h, 90h and 98h set read_mode to 0 (array), 1 (status), 2 (identification) and 3 (query) one cycle after the write.
- R3: Code 40h, or its alternate 10h, arms program. The next write cycle, whatever its data, causes pgm_start to pulse for one cycle. It also presents that cycle's address on op_addr and its data on op_data, and sets read_mode to 1.
- R4: Code 20h arms erase. A following write with low byte D0h pulses ers_start, puts that cycle's address on op_addr and sets read_mode to 1.
- R5: After 20h, a write with any low byte other than D0h starts nothing. It pulses seq_err and sets read_mode to 0.
- R6: While sq_busy is high, only B0h is accepted, and it pulses susp_req. Every other code leaves read_mode unchanged and raises no pulse.
- R7: While a program is held (sq_susp high, sq_busy low), the accepted codes are FFh, 70h, 90h, 98h, 40h, 10h and D0h. D0h pulses resume_req. 20h, 60h and all other codes are ignored.
- R8: While an erase is held, 60h is accepted in addition to the codes of R7. A program may run during the hold, and D0h issued after that program finishes pulses resume_req.
- R9: Code 60h arms lock when it is legal. The next write pulses lock_req and puts that cycle's address and data on op_addr and op_data.
- R10: With no operation busy or held, B0h, D0h and any code not listed in R2 to R9 are ignored.
- R11: A clock edge where bus_ce or bus_we is low has no effect.
- R12: At most one of the request pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any pending sequence |
| bus_ce | input | 1 | Chip enable, active high |
| bus_we | input | 1 | Write enable, active high |
| bus_data | input | DW | Write data; bits 7:0 carry the command code |
| bus_addr | input | AW | Write address |
| sq_busy | input | 1 | Sequencer is running an operation |
| sq_susp | input | 1 | Sequencer holds a suspended operation |
| read_mode | output | 2 | 0 array, 1 status, 2 identification, 3 query |
| pgm_start | output | 1 | Program start request pulse |
| ers_start | output | 1 | Block erase start request pulse |
| lock_req | output | 1 | Lock request pulse |
| susp_req | output | 1 | Suspend request pulse |
| resume_req | output | 1 | Resume request pulse |
| seq_err | output | 1 | Erase sequence error pulse |
| op_addr | output | AW | Address captured with the last request |
| op_data | output | DW | Data captured with the last program or lock request |

## Verification
The bench builds the block with AW=8, DW=16 and the alternate program code enabled. This keeps the addresses small and brings the 10h path within reach. All 256 code values are swept in each of the four sequencer contexts: ready, busy, program held and erase held. Each code is followed by a non-command data word, so that an armed sequence shows up as the matching start, lock or error pulse, and an ignored code shows up as nothing. A directed pass covers the erase confirm address, a program nested inside an erase hold, and writes with a strobe low.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_STATUS = 2'd1, RD_IDENT = 2'd2, RD_QUERY = 2'd3} rd_mode_t;
   typedef enum logic [1:0] {SQ_READY, SQ_PGM_ARG, SQ_ERS_CONF, SQ_LOCK_ARG} seq_st_t;
   typedef enum logic [1:0] {OP_NONE, OP_PGM, OP_ERS} op_kind_t;
   typedef enum logic [3:0] {
      K_NONE, K_RD_ARR, K_RD_STAT, K_RD_ID, K_RD_QRY,
      K_PGM_SET, K_ERS_SET, K_LOCK_SET, K_SUSP, K_RESUME
   } cmd_kind_t;

   localparam logic [7:0] C_RD_ARR  = 8'hFF;
   localparam logic [7:0] C_RD_STAT = 8'h70;
   localparam logic [7:0] C_RD_ID   = 8'h90;
   localparam logic [7:0] C_RD_QRY  = 8'h98;
   localparam logic [7:0] C_PGM     = 8'h40;
   localparam logic [7:0] C_PGM_ALT = 8'h10;
   localparam logic [7:0] C_ERS     = 8'h20;
   localparam logic [7:0] C_CONF    = 8'hD0;
   localparam logic [7:0] C_SUSP    = 8'hB0;
   localparam logic [7:0] C_LOCK    = 8'h60;
endpackage

// File: rtl/flash_cmd_classify.sv
module flash_cmd_classify
   import flash_cmd_pkg::*;
#(
   parameter bit ALT_PGM_EN = 1'b1
) (
   input  logic [7:0] code,
   output cmd_kind_t  kind
);
   logic alt_hit;

   generate
      if (ALT_PGM_EN) begin : g_alt
         assign alt_hit = (code == C_PGM_ALT);
      end else begin : g_no_alt
         assign alt_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      kind = K_NONE;
      unique case (code)
         C_RD_ARR:  kind = K_RD_ARR;
         C_RD_STAT: kind = K_RD_STAT;
         C_RD_ID:   kind = K_RD_ID;
         C_RD_QRY:  kind = K_RD_QRY;
         C_PGM:     kind = K_PGM_SET;
         C_ERS:     kind = K_ERS_SET;
         C_LOCK:    kind = K_LOCK_SET;
         C_SUSP:    kind = K_SUSP;
         C_CONF:    kind = K_RESUME;
         default:   kind = alt_hit ? K_PGM_SET : K_NONE;
      endcase
   end
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
   import flash_cmd_pkg::*;
(
   input  cmd_kind_t kind,
   input  logic      busy,
   input  logic      susp,
   input  op_kind_t  held_op,
   output logic      accept
);
   logic is_read;

   assign is_read = (kind == K_RD_ARR) || (kind == K_RD_STAT) ||
                    (kind == K_RD_ID)  || (kind == K_RD_QRY);

   always_comb begin
      if (busy) begin
         accept = (kind == K_SUSP);
      end else if (susp) begin
         accept = is_read || (kind == K_PGM_SET) || (kind == K_RESUME) ||
                  ((kind == K_LOCK_SET) && (held_op == OP_ERS));
      end else begin
         accept = is_read || (kind == K_PGM_SET) || (kind == K_ERS_SET) ||
                  (kind == K_LOCK_SET);
      end
   end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_cmd_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_vld,
   input  logic [DW-1:0] data,
   input  logic [AW-1:0] addr,
   input  cmd_kind_t     kind,
   input  logic          accept,
   input  logic          susp,
   output op_kind_t      held_op,
   output rd_mode_t      mode,
   output logic          pgm_start,
   output logic          ers_start,
   output logic          lock_req,
   output logic          susp_req,
   output logic          resume_req,
   output logic          seq_err,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);
   seq_st_t st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_READY;
         held_op    <= OP_NONE;
         mode       <= RD_ARRAY;
         pgm_start  <= 1'b0;
         ers_start  <= 1'b0;
         lock_req   <= 1'b0;
         susp_req   <= 1'b0;
         resume_req <= 1'b0;
         seq_err    <= 1'b0;
         op_addr    <= '0;
         op_data    <= '0;
      end else begin
         pgm_start  <= 1'b0;
         ers_start  <= 1'b0;
         lock_req   <= 1'b0;
         susp_req   <= 1'b0;
         resume_req <= 1'b0;
         seq_err    <= 1'b0;
         if (wr_vld) begin
            unique case (st)
               SQ_READY: if (accept) begin
                  unique case (kind)
                     K_RD_ARR:   mode <= RD_ARRAY;
                     K_RD_STAT:  mode <= RD_STATUS;
                     K_RD_ID:    mode <= RD_IDENT;
                     K_RD_QRY:   mode <= RD_QUERY;
                     K_PGM_SET:  st <= SQ_PGM_ARG;
                     K_ERS_SET:  st <= SQ_ERS_CONF;
                     K_LOCK_SET: st <= SQ_LOCK_ARG;
                     K_SUSP: begin
                        susp_req <= 1'b1;
                        mode     <= RD_STATUS;
                     end
                     K_RESUME: begin
                        resume_req <= 1'b1;
                        mode       <= RD_STATUS;
                     end
                     default: ;
                  endcase
               end
               SQ_PGM_ARG: begin
                  pgm_start <= 1'b1;
                  op_addr   <= addr;
                  op_data   <= data;
                  mode      <= RD_STATUS;
                  if (!susp) held_op <= OP_PGM;
                  st        <= SQ_READY;
               end
               SQ_ERS_CONF: begin
                  if (data[7:0] == C_CONF) begin
                     ers_start <= 1'b1;
                     op_addr   <= addr;
                     mode      <= RD_STATUS;
                     held_op   <= OP_ERS;
                  end else begin
                     seq_err <= 1'b1;
                     mode    <= RD_ARRAY;
                  end
                  st <= SQ_READY;
               end
               SQ_LOCK_ARG: begin
                  lock_req <= 1'b1;
                  op_addr  <= addr;
                  op_data  <= data;
                  st       <= SQ_READY;
               end
               default: st <= SQ_READY;
            endcase
         end
      end
   end

   // R3
   pgm_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && st == SQ_PGM_ARG) |=> (pgm_start && mode == RD_STATUS));

   // R5
   ers_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && st == SQ_ERS_CONF && data[7:0] != C_CONF) |=>
      (seq_err && !ers_start && mode == RD_ARRAY));

   // R4
   ers_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && st == SQ_ERS_CONF && data[7:0] == C_CONF) |=>
      (ers_start && op_addr == $past(addr)));
endmodule

// File: rtl/flash_cmd_ui.sv
module flash_cmd_ui
   import flash_cmd_pkg::*;
#(
   parameter int AW         = 8,
   parameter int DW         = 16,
   parameter bit ALT_PGM_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_ce,
   input  logic          bus_we,
   input  logic [DW-1:0] bus_data,
   input  logic [AW-1:0] bus_addr,
   input  logic          sq_busy,
   input  logic          sq_susp,
   output logic [1:0]    read_mode,
   output logic          pgm_start,
   output logic          ers_start,
   output logic          lock_req,
   output logic          susp_req,
   output logic          resume_req,
   output logic          seq_err,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);
   localparam int CODE_W = 8;

   generate
      if (DW < CODE_W) begin : g_bad_dw
         $error("flash_cmd_ui: DW must hold a command byte");
      end
      if (AW < 1) begin : g_bad_aw
         $error("flash_cmd_ui: AW must be at least 1");
      end
   endgenerate

   logic      wr_vld;
   logic      accept;
   cmd_kind_t kind;
   op_kind_t  held_op;
   rd_mode_t  mode;

   assign wr_vld    = bus_ce && bus_we;
   assign read_mode = mode;

   flash_cmd_classify #(.ALT_PGM_EN(ALT_PGM_EN)) u_cls (
      .code (bus_data[CODE_W-1:0]),
      .kind (kind)
   );

   flash_cmd_gate u_gate (
      .kind    (kind),
      .busy    (sq_busy),
      .susp    (sq_susp),
      .held_op (held_op),
      .accept  (accept)
   );

   flash_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_vld     (wr_vld),
      .data       (bus_data),
      .addr       (bus_addr),
      .kind       (kind),
      .accept     (accept),
      .susp       (sq_susp),
      .held_op    (held_op),
      .mode       (mode),
      .pgm_start  (pgm_start),
      .ers_start  (ers_start),
      .lock_req   (lock_req),
      .susp_req   (susp_req),
      .resume_req (resume_req),
      .seq_err    (seq_err),
      .op_addr    (op_addr),
      .op_data    (op_data)
   );

   // R6
   busy_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && sq_busy && bus_data[CODE_W-1:0] != C_SUSP) |=>
      (!pgm_start && !ers_start && !lock_req && !resume_req && !susp_req && $stable(read_mode)));

   // R11
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_vld |=> (!pgm_start && !ers_start && !lock_req && !susp_req &&
                   !resume_req && !seq_err && $stable(read_mode)));

   // R12
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pgm_start, ers_start, lock_req, susp_req, resume_req, seq_err}));

   // R1
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (read_mode == 2'd0 && !pgm_start && !ers_start && !susp_req);
      end
   end
endmodule

// File: tb/sim_flash_cmd_ui.sv
module sim_flash_cmd_ui;
   localparam int CLK_NS = 10;
   localparam int AW = 8;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_ce = 1'b0, bus_we = 1'b0;
   logic [DW-1:0] bus_data = '0;
   logic [AW-1:0] bus_addr = '0;
   logic sq_busy = 1'b0, sq_susp = 1'b0;
   logic [1:0] read_mode;
   logic pgm_start, ers_start, lock_req, susp_req, resume_req, seq_err;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   flash_cmd_ui #(.AW(AW), .DW(DW), .ALT_PGM_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_we(bus_we),
      .bus_data(bus_data), .bus_addr(bus_addr), .sq_busy(sq_busy), .sq_susp(sq_susp),
      .read_mode(read_mode), .pgm_start(pgm_start), .ers_start(ers_start),
      .lock_req(lock_req), .susp_req(susp_req), .resume_req(resume_req),
      .seq_err(seq_err), .op_addr(op_addr), .op_data(op_data)
   );

   // pulse vector order: pgm, ers, lock, susp, resume, err
   function automatic logic [5:0] pulses();
      return {pgm_start, ers_start, lock_req, susp_req, resume_req, seq_err};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d, input logic [7:0] a);
      @(negedge clk);
      bus_ce = 1'b1; bus_we = 1'b1; bus_data = d; bus_addr = a;
      @(negedge clk);
      bus_ce = 1'b0; bus_we = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; sq_busy = 1'b0; sq_susp = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic int mode_after(input int c, input int prev);
      case (c)
         'hFF: return 0;
         'h70: return 1;
         'h90: return 2;
         'h98: return 3;
         default: return prev;
      endcase
   endfunction

   // ctx: 0 ready, 1 program held, 2 erase held
   task automatic prep(input int ctx);
      do_reset();
      if (ctx == 1) begin
         wr(16'h0040, 8'h00);
         wr(16'h1234, 8'h11);
         sq_busy = 1'b1; @(negedge clk);
         sq_busy = 1'b0; sq_susp = 1'b1;
      end else if (ctx == 2) begin
         wr(16'h0020, 8'h00);
         wr(16'h00D0, 8'h42);
         sq_busy = 1'b1;
         wr(16'h00B0, 8'h00);
         sq_busy = 1'b0; sq_susp = 1'b1;
      end
      wr(16'h0070, 8'h00);
   endtask

   task automatic sweep(input int ctx, input string req);
      for (int c = 0; c < 256; c++) begin
         bit rd, pg, er, lk, rs;
         int m1, m2;
         logic [5:0] e1, e2;
         prep(ctx);
         rd = (c == 'hFF) || (c == 'h70) || (c == 'h90) || (c == 'h98);
         pg = (c == 'h40) || (c == 'h10);
         er = (ctx == 0) && (c == 'h20);
         lk = (c == 'h60) && (ctx != 1);
         rs = (ctx != 0) && (c == 'hD0);
         m1 = rd ? mode_after(c, 1) : 1;
         e1 = {1'b0, 1'b0, 1'b0, 1'b0, rs, 1'b0};
         wr(16'(c), 8'h05);
         chk({req, " mode"}, int'(read_mode), m1);
         chk({req, " pulse"}, int'(pulses()), int'(e1));
         e2 = {pg, 1'b0, lk, 1'b0, 1'b0, er};
         m2 = pg ? 1 : (er ? 0 : m1);
         wr(16'h55AA, 8'h3C);
         chk({req, " follow pulse"}, int'(pulses()), int'(e2));
         chk({req, " follow mode"}, int'(read_mode), m2);
         if (pg) begin
            chk("R3 program addr", int'(op_addr), 'h3C);
            chk("R3 program data", int'(op_data), 'h55AA);
         end
         if (lk) chk("R9 lock data", int'(op_data), 'h55AA);
      end
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      chk("R1 reset mode", int'(read_mode), 0);
      chk("R1 reset pulses", int'(pulses()), 0);
      do_reset();
      chk("R1 after reset mode", int'(read_mode), 0);

      // R2 R3 R4 R5 R9 R10: every code with nothing busy or held
      sweep(0, "R10 ready");
      // R7: program held
      sweep(1, "R7 program held");
      // R8: erase held
      sweep(2, "R8 erase held");

      // R6: every code while busy
      prep(0);
      sq_busy = 1'b1;
      for (int c = 0; c < 256; c++) begin
         wr(16'(c), 8'h01);
         chk("R6 busy pulse", int'(pulses()), (c == 'hB0) ? 'h04 : 0);
         chk("R6 busy mode", int'(read_mode), 1);
      end
      sq_busy = 1'b0;

      // R4: confirm address captured
      do_reset();
      wr(16'h0020, 8'h00);
      wr(16'hAAD0, 8'h9E);
      chk("R4 erase start", int'(ers_start), 1);
      chk("R4 erase addr", int'(op_addr), 'h9E);
      chk("R4 erase mode", int'(read_mode), 1);

      // R8: program nested in an erase hold, then erase resume
      prep(2);
      wr(16'h0020, 8'h00);
      chk("R8 erase setup ignored", int'(pulses()), 0);
      wr(16'h0040, 8'h00);
      wr(16'hBEEF, 8'h07);
      chk("R8 nested program", int'(pgm_start), 1);
      sq_busy = 1'b1;
      wr(16'h00D0, 8'h00);
      chk("R8 resume blocked while busy", int'(resume_req), 0);
      sq_busy = 1'b0;
      wr(16'h00D0, 8'h00);
      chk("R8 erase resume", int'(resume_req), 1);

      // R11: strobes low
      do_reset();
      @(negedge clk);
      bus_ce = 1'b0; bus_we = 1'b1; bus_data = 16'h0098;
      @(negedge clk);
      bus_ce = 1'b1; bus_we = 1'b0; bus_data = 16'h0090;
      @(negedge clk);
      bus_ce = 1'b0; bus_we = 1'b0;
      chk("R11 strobes low mode", int'(read_mode), 0);
      chk("R11 strobes low pulses", int'(pulses()), 0);

      // R12: one pulse per cycle across a start
      wr(16'h0040, 8'h00);
      wr(16'h0001, 8'h02);
      chk("R12 single pulse", $countones(pulses()), 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule